// File: doc/BRIEF.md
# Packed SIMD add/subtract unit with bank-typed registers

This block is a 32-bit packed-SIMD adder/subtractor sitting in front of a small register file of 32 entries. An issued operation names two source registers, a destination register, an operation code and a 2-bit mode. The opcode picks add, subtract, halving add or halving subtract. The lane layout and the signedness are not carried by the opcode. They follow from the register bank that the three indices share. The chosen lane operation is applied to every lane at once, and the packed result is written back to the destination register.

Mode 00 gives wrapping arithmetic, and mode 01 gives saturating arithmetic. Halving operations form each lane at one bit wider than the lane, then drop the lowest bit. Operand combinations that cannot be executed raise a one-cycle illegal flag and leave the register file untouched. A load port and a combinational read port give the surrounding pipeline, and the testbench, access to register contents.

Top module: `packed_addsub_unit`

## Requirements
- R1: Bank decode by register index: 2..7 are four signed 8-bit lanes, 8..15 four unsigned 8-bit lanes, 16..23 two signed 16-bit lanes, 24..29 two unsigned 16-bit lanes, 30..31 one signed 32-bit lane; lane 0 occupies the least significant bits.
- R2: Register 0 always reads as zero; a load to register 0 is discarded.
- R3: opCode 0 adds, 1 subtracts (srcA minus srcB), 2 is halving add, 3 is halving subtract; with modeSel 00 add/subtract wraps modulo the lane width, giving identical bits for the signed and unsigned bank of one width.
- R4: With modeSel 01 in a signed bank, add/subtract clamps each lane to its two's-complement minimum or maximum on overflow.
- R5: With modeSel 01 in an unsigned bank, add clamps an overflowing lane to all ones and subtract clamps an underflowing lane to zero.
- R6: Halving operations (modeSel 00) compute each lane at lane width plus one bit, sign- or zero-extended by bank, and shift right by one with truncation.
- R7: No carry or borrow crosses a lane boundary.
- R8: An issue is illegal, and writes nothing, if the three indices are not all in one bank, if any index is 0 or 1, if modeSel is 10 or 11, or if a halving opcode uses modeSel 01.
- R9: A legal issue writes the destination at the clock edge that samples issueValid, and the result is visible on readData after that edge; illegalFlag is high for exactly the cycle after an illegal issue.
- R10: After reset every register reads zero and illegalFlag is low.
- R11: loadValid writes loadData into loadIdx at the clock edge; when an issue and a load fall in the same cycle, the issue's writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load a register from loadData |
| loadIdx | input | 5 | Register written by a load |
| loadData | input | DATA_W | Data written by a load |
| issueValid | input | 1 | Issue an arithmetic operation this cycle |
| opCode | input | 2 | 0 add, 1 sub, 2 halving add, 3 halving sub |
| modeSel | input | 2 | 00 wrapping, 01 saturating, others illegal |
| srcA | input | 5 | First source register |
| srcB | input | 5 | Second source register |
| dstIdx | input | 5 | Destination register |
| readIdx | input | 5 | Register shown on readData |
| readData | output | DATA_W | Combinational register contents |
| illegalFlag | output | 1 | Previous-cycle issue was illegal |

## Verification
The assertions watch, on every cycle, that register 0 stays zero, that each legal writeback lands in the named destination with the value computed the cycle before, that saturating and halving strobes are never combined, that unsigned saturation never wraps below or above the first operand, and that nothing is written when illegalFlag is about to rise. Exact lane values cannot be shown by those checks. Signed clamping at both extremes, the truncation direction of halving on negative sums, lane isolation, and the equality of wrapped results across the two signedness banks can only be shown by the bench's directed scenarios. The same holds for each illegal operand combination.

// File: rtl/pk_addsub_pkg.sv
package pk_addsub_pkg;
  localparam int REG_N = 32;
  localparam int IDX_W = $clog2(REG_N);

  typedef enum logic [2:0] {BK_NONE, BK_S8, BK_U8, BK_S16, BK_U16, BK_S32} bank_e;
  typedef enum logic [1:0] {LW_8, LW_16, LW_32} laneWidth_e;

  typedef struct packed {
    logic       wrEn;
    laneWidth_e width;
    logic       signedOp;
    logic       satEn;
    logic       halveEn;
    logic       subEn;
  } aluStrobe_t;

  // bank ranges are part of the behaviour: lane type follows the index
  function automatic bank_e bankOf(input logic [IDX_W-1:0] idx);
    if (idx < 5'd2)       return BK_NONE;
    else if (idx < 5'd8)  return BK_S8;
    else if (idx < 5'd16) return BK_U8;
    else if (idx < 5'd24) return BK_S16;
    else if (idx < 5'd30) return BK_U16;
    else                  return BK_S32;
  endfunction
endpackage

// File: rtl/pk_addsub_ctrl.sv
module pk_addsub_ctrl
  import pk_addsub_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [1:0]       opCode,
  input  logic [1:0]       modeSel,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  input  logic [IDX_W-1:0] dstIdx,
  output aluStrobe_t       stb,
  output logic             illegalFlag
);
  bank_e bankA, bankB, bankD;
  logic  sameBank, modeOk, illegalNow;

  always_comb begin
    bankA    = bankOf(srcA);
    bankB    = bankOf(srcB);
    bankD    = bankOf(dstIdx);
    sameBank = (bankA == bankB) && (bankA == bankD) && (bankA != BK_NONE);
    modeOk   = (modeSel == 2'b00) || (modeSel == 2'b01 && !opCode[1]);
    illegalNow = issueValid && !(sameBank && modeOk);

    stb.wrEn     = issueValid && sameBank && modeOk;
    stb.satEn    = modeSel[0];
    stb.halveEn  = opCode[1];
    stb.subEn    = opCode[0];
    stb.signedOp = (bankD == BK_S8) || (bankD == BK_S16) || (bankD == BK_S32);
    case (bankD)
      BK_S16, BK_U16: stb.width = LW_16;
      BK_S32:         stb.width = LW_32;
      default:        stb.width = LW_8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalFlag <= 1'b0;
    else       illegalFlag <= illegalNow;
  end

  // R6: halving and saturation never combine on a real write
  a_r6_halve_not_sat: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrEn && stb.satEn, stb.wrEn && stb.halveEn}));

  // R8: an issue that raises the flag next cycle must not have written
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !stb.wrEn) |=> illegalFlag);

  // R8: writes only ever target an arithmetic bank
  a_r8_dst_in_bank: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (dstIdx > 5'd1));
endmodule

// File: rtl/pk_addsub_path.sv
module pk_addsub_path
  import pk_addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        stb,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic              loadValid,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic [IDX_W-1:0]  readIdx,
  output logic [DATA_W-1:0] readData
);
  localparam int WIDTH_N = 3;

  logic [DATA_W-1:0] rf [REG_N];
  logic [DATA_W-1:0] opA, opB, result;

  assign opA = rf[srcA];
  assign opB = rf[srcB];
  assign readData = rf[readIdx];

  for (genvar gw = 0; gw < WIDTH_N; gw++) begin : g_width
    localparam int LW = 8 << gw;
    localparam int LN = DATA_W / LW;
    logic [DATA_W-1:0] wRes;

    for (genvar gl = 0; gl < LN; gl++) begin : g_lane
      logic [LW-1:0] aL, bL, rL;
      logic [LW:0]   aX, bX, sX;

      assign aL = opA[gl*LW +: LW];
      assign bL = opB[gl*LW +: LW];

      always_comb begin
        aX = {stb.signedOp & aL[LW-1], aL};
        bX = {stb.signedOp & bL[LW-1], bL};
        sX = stb.subEn ? (aX - bX) : (aX + bX);
        if (stb.halveEn)
          rL = sX[LW:1];
        else if (stb.satEn && stb.signedOp && (sX[LW] != sX[LW-1]))
          rL = sX[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
        else if (stb.satEn && !stb.signedOp && sX[LW])
          rL = stb.subEn ? '0 : '1;
        else
          rL = sX[LW-1:0];
      end

      assign wRes[gl*LW +: LW] = rL;

      // R5: unsigned saturating add never drops below the first operand
      a_r5_usat_add_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
        (stb.satEn && !stb.halveEn && !stb.signedOp && !stb.subEn) |-> (rL >= aL));
      // R5: unsigned saturating subtract never exceeds the first operand
      a_r5_usat_sub_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
        (stb.satEn && !stb.halveEn && !stb.signedOp && stb.subEn) |-> (rL <= aL));
    end
  end

  always_comb begin
    case (stb.width)
      LW_16:   result = g_width[1].wRes;
      LW_32:   result = g_width[2].wRes;
      default: result = g_width[0].wRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) rf[i] <= '0;
    end else if (stb.wrEn) begin
      rf[dstIdx] <= result;
    end else if (loadValid && loadIdx != '0) begin
      rf[loadIdx] <= loadData;
    end
  end

  // R2: register 0 holds zero on every cycle
  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    rf[0] == '0);

  // R9: a legal issue lands in its destination at the sampling edge
  a_r9_writeback: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(stb.wrEn)) |-> (rf[$past(dstIdx)] == $past(result)));
endmodule

// File: rtl/packed_addsub_unit.sv
module packed_addsub_unit
  import pk_addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [4:0]        loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic              issueValid,
  input  logic [1:0]        opCode,
  input  logic [1:0]        modeSel,
  input  logic [4:0]        srcA,
  input  logic [4:0]        srcB,
  input  logic [4:0]        dstIdx,
  input  logic [4:0]        readIdx,
  output logic [DATA_W-1:0] readData,
  output logic              illegalFlag
);
  aluStrobe_t stb;

  pk_addsub_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opCode(opCode),
    .modeSel(modeSel), .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx),
    .stb(stb), .illegalFlag(illegalFlag)
  );

  pk_addsub_path #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .srcA(srcA), .srcB(srcB),
    .dstIdx(dstIdx), .loadValid(loadValid), .loadIdx(loadIdx),
    .loadData(loadData), .readIdx(readIdx), .readData(readData)
  );
endmodule

// File: tb/test_packed_addsub_unit.sv
module test_packed_addsub_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [4:0]  loadIdx = '0;
  logic [31:0] loadData = '0;
  logic        issueValid = 1'b0;
  logic [1:0]  opCode = '0;
  logic [1:0]  modeSel = '0;
  logic [4:0]  srcA = '0, srcB = '0, dstIdx = '0, readIdx = '0;
  logic [31:0] readData;
  logic        illegalFlag;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  packed_addsub_unit i_packed_addsub_unit (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIdx(loadIdx),
    .loadData(loadData), .issueValid(issueValid), .opCode(opCode),
    .modeSel(modeSel), .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx),
    .readIdx(readIdx), .readData(readData), .illegalFlag(illegalFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    loadValid = 1'b1; loadIdx = idx; loadData = val;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic issueOp(input logic [1:0] op, input logic [1:0] md,
                         input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    @(negedge clk);
    issueValid = 1'b1; opCode = op; modeSel = md; srcA = a; srcB = b; dstIdx = d;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [4:0] idx);
    readIdx = idx;
    return 32'h0;
  endfunction

  task automatic checkReg(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    readIdx = idx;
    #1;
    check(tag, readData, exp);
  endtask

  task automatic testReset;
    checkReg("R10 reg2 zero", 5'd2, 32'h0);
    checkReg("R10 reg31 zero", 5'd31, 32'h0);
    check("R10 flag low", {31'b0, illegalFlag}, 32'h0);
  endtask

  task automatic testZeroReg;
    loadReg(5'd0, 32'hDEADBEEF);
    checkReg("R2 reg0 ignores load", 5'd0, 32'h0);
    loadReg(5'd5, 32'h1234_5678);
    checkReg("R11 load lands", 5'd5, 32'h1234_5678);
  endtask

  task automatic testWrap8;
    loadReg(5'd2, 32'h7F80_1005); loadReg(5'd3, 32'h01FF_0203);
    loadReg(5'd8, 32'h7F80_1005); loadReg(5'd9, 32'h01FF_0203);
    issueOp(2'd0, 2'b00, 5'd2, 5'd3, 5'd4);
    check("R9 flag low after legal", {31'b0, illegalFlag}, 32'h0);
    checkReg("R3 R1 signed byte wrap add", 5'd4, 32'h807F_1208);
    issueOp(2'd0, 2'b00, 5'd8, 5'd9, 5'd10);
    checkReg("R3 unsigned byte wrap add same bits", 5'd10, 32'h807F_1208);
    issueOp(2'd1, 2'b00, 5'd8, 5'd9, 5'd11);
    checkReg("R3 byte wrap sub", 5'd11, 32'h7E81_0E02);
  endtask

  task automatic testSat8;
    issueOp(2'd0, 2'b01, 5'd2, 5'd3, 5'd6);
    checkReg("R4 signed byte sat add", 5'd6, 32'h7F80_1208);
    issueOp(2'd0, 2'b01, 5'd8, 5'd9, 5'd12);
    checkReg("R5 unsigned byte sat add", 5'd12, 32'h80FF_1208);
    issueOp(2'd1, 2'b01, 5'd8, 5'd9, 5'd13);
    checkReg("R5 unsigned byte sat sub", 5'd13, 32'h7E00_0E02);
  endtask

  task automatic testHalve16;
    loadReg(5'd16, 32'h7FFF_0000); loadReg(5'd17, 32'h0001_8000);
    loadReg(5'd24, 32'h7FFF_0000); loadReg(5'd25, 32'h0001_8000);
    issueOp(2'd3, 2'b00, 5'd16, 5'd17, 5'd18);
    checkReg("R6 signed half halving sub", 5'd18, 32'h3FFF_4000);
    issueOp(2'd3, 2'b00, 5'd24, 5'd25, 5'd26);
    checkReg("R6 unsigned half halving sub", 5'd26, 32'h3FFF_C000);
    loadReg(5'd19, 32'h8000_7FFF); loadReg(5'd20, 32'hFFFF_0001);
    issueOp(2'd2, 2'b00, 5'd19, 5'd20, 5'd21);
    checkReg("R6 signed halving add truncates", 5'd21, 32'hBFFF_4000);
  endtask

  task automatic testLanes;
    loadReg(5'd22, 32'h0000_FFFF); loadReg(5'd23, 32'h0000_0001);
    issueOp(2'd0, 2'b00, 5'd22, 5'd23, 5'd22);
    checkReg("R7 half lane carry stays", 5'd22, 32'h0000_0000);
    loadReg(5'd7, 32'h00FF_00FF); loadReg(5'd5, 32'h0001_0001);
    issueOp(2'd0, 2'b00, 5'd7, 5'd5, 5'd7);
    checkReg("R7 byte lane carry stays", 5'd7, 32'h0000_0000);
    loadReg(5'd30, 32'h7FFF_FFFF); loadReg(5'd31, 32'h0000_0001);
    issueOp(2'd0, 2'b01, 5'd30, 5'd31, 5'd31);
    checkReg("R4 R1 word sat add", 5'd31, 32'h7FFF_FFFF);
    loadReg(5'd31, 32'h0000_0001);
    issueOp(2'd0, 2'b00, 5'd30, 5'd31, 5'd30);
    checkReg("R1 word wrap add", 5'd30, 32'h8000_0000);
    issueOp(2'd1, 2'b01, 5'd30, 5'd31, 5'd30);
    checkReg("R4 word sat sub at minimum", 5'd30, 32'h8000_0000);
  endtask

  task automatic testIllegal;
    loadReg(5'd3, 32'hCAFE_0001);
    issueOp(2'd0, 2'b00, 5'd2, 5'd8, 5'd3);
    check("R8 mixed bank flag", {31'b0, illegalFlag}, 32'h1);
    checkReg("R8 mixed bank no write", 5'd3, 32'hCAFE_0001);
    @(negedge clk);
    check("R9 flag lasts one cycle", {31'b0, illegalFlag}, 32'h0);
    issueOp(2'd0, 2'b00, 5'd2, 5'd3, 5'd0);
    check("R8 dst reg0 flag", {31'b0, illegalFlag}, 32'h1);
    issueOp(2'd0, 2'b10, 5'd2, 5'd2, 5'd3);
    check("R8 mode 10 flag", {31'b0, illegalFlag}, 32'h1);
    issueOp(2'd2, 2'b01, 5'd2, 5'd2, 5'd3);
    check("R8 halving sat flag", {31'b0, illegalFlag}, 32'h1);
    checkReg("R8 reg3 unchanged", 5'd3, 32'hCAFE_0001);
  endtask

  task automatic testConflict;
    loadReg(5'd14, 32'h0000_0010); loadReg(5'd15, 32'h0000_0001);
    @(negedge clk);
    issueValid = 1'b1; opCode = 2'd0; modeSel = 2'b00;
    srcA = 5'd14; srcB = 5'd15; dstIdx = 5'd15;
    loadValid = 1'b1; loadIdx = 5'd15; loadData = 32'hFFFF_FFFF;
    @(negedge clk);
    issueValid = 1'b0; loadValid = 1'b0;
    checkReg("R11 issue beats load", 5'd15, 32'h0000_0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset;
    rstN = 1'b1;
    testReset;
    testZeroReg;
    testWrap8;
    testSat8;
    testHalve16;
    testLanes;
    testIllegal;
    testConflict;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule